// File: doc/BRIEF.md
# Predicated BF16 Fused Multiply-Subtract Lane Array

This block takes three packed vectors of 16-bit BFloat16 lanes and a byte-granular predicate. Each active lane returns the addend minus the product of the two sources, computed as one fused operation. The product is never rounded on its own. The exact sum is rounded once, to nearest with ties to even. An inactive lane hands its addend through bit for bit. The result vector is meant to be written back over the register that supplied the addend.

Special operands follow one fixed policy. Any NaN gives the default quiet NaN 0x7FC0, and so do infinity times zero and opposing infinities. Subnormal operands and subnormal results are flushed to signed zero, and overflow saturates to a signed infinity. The arithmetic is combinational per lane. An optional output register captures a result when the input strobe is high and holds it otherwise. The lane count is a parameter.

Top module: `bfms_top`

## Requirements
- R1: Lane e occupies bits [16e+15:16e] of each vector. Lane e is active exactly when predMask bit 2e is 1. The odd predicate bits select nothing.
- R2: An active lane outputs srcAcc − srcA × srcB. The sign of srcA is inverted and the sign of srcAcc is kept. The sum is exact before a single final rounding, so (1+2^-7)² subtracted from 1+2^-6 gives −2^-14 (0xB880).
- R3: An inactive lane outputs its srcAcc lane unchanged, including NaN bit patterns such as 0x7F81.
- R4: When no lane is active, both source vectors are forced to zero and every output lane equals its srcAcc lane.
- R5: Rounding is to nearest, ties to even, to 8 exponent bits and 7 fraction bits. For example, 1 + 2^-8 gives 0x3F80 and (1+2^-7) + 2^-8 gives 0x3F82.
- R6: A result whose magnitude exceeds the largest finite value after rounding becomes infinity with the sign of the sum (0x7F80 or 0xFF80).
- R7: A NaN in any operand, infinity × zero, or an infinite product meeting an infinite addend of opposite effective sign gives 0x7FC0.
- R8: An infinite product gives infinity with the sign of the negated product. Otherwise an infinite addend is returned as it is.
- R9: Inputs with exponent field 0 count as signed zero. A finite result with a biased exponent ≤ 0 becomes zero with the sign of the sum.
- R10: A nonzero sum that cancels exactly gives +0. A zero negated product plus a zero addend gives a zero with their common sign if both signs match, and +0 otherwise.
- R11: With the output register enabled, result and outValid update one clock after an edge where inValid is 1. outValid is 0 after an edge where inValid is 0, and result then holds. Reset clears both to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Strobe that captures a new result |
| srcA | input | 16*LANES | Multiplicand vector; its sign is inverted |
| srcB | input | 16*LANES | Multiplier vector |
| srcAcc | input | 16*LANES | Addend vector, also the pass-through value |
| predMask | input | 2*LANES | One bit per byte; the even bit of each lane enables it |
| outValid | output | 1 | High for one cycle after a capture |
| result | output | 16*LANES | Result vector to be written over the addend |

## Verification
One case depends on the fusion itself. Its exact difference is 2^-14, and a design that rounded the product first would return zero. Tie cases on both sides of an even fraction catch rounding that goes away from zero or truncates. Cases just above and just below a tie catch a lost sticky bit. The predicate cases put a NaN on an inactive addend and set only odd mask bits. A design that reads the wrong predicate bit, or that quiets or recomputes inactive lanes, returns the wrong pattern. The special-value cases cover each of the following:
- opposing infinities;
- infinity times zero;
- overflow;
- flushed subnormals;
- exact cancellation.

A design with the wrong sign rule returns −0 where +0 is expected, or returns a finite value where infinity or the default NaN is expected.

// File: rtl/bfms_pkg.sv
package bfms_pkg;
  localparam int LANE_W  = 16;
  localparam int EXP_W   = 8;
  localparam int FRAC_W  = 7;
  localparam int FRAME_W = 20;
  localparam logic [LANE_W-1:0] QNAN_DEFAULT = 16'h7FC0;

  typedef struct packed {
    logic capture;
    logic zeroSrc;
  } ctlStrobe_t;

  function automatic logic [FRAME_W-1:0] shiftSticky(input logic [FRAME_W-1:0] x,
                                                     input logic [10:0] amt);
    logic [FRAME_W-1:0] y;
    logic [FRAME_W-1:0] lostMask;
    if (amt >= 11'(FRAME_W)) begin
      y = '0;
      y[0] = |x;
    end else begin
      lostMask = (FRAME_W'(1) << amt) - FRAME_W'(1);
      y = x >> amt;
      y[0] = y[0] | (|(x & lostMask));
    end
    return y;
  endfunction
endpackage

// File: rtl/bfms_lane.sv
module bfms_lane
  import bfms_pkg::*;
(
  input  logic [LANE_W-1:0] opA,
  input  logic [LANE_W-1:0] opB,
  input  logic [LANE_W-1:0] opC,
  output logic [LANE_W-1:0] laneOut
);
  logic [EXP_W-1:0] aExp, bExp, cExp;
  logic aZero, bZero, cZero, aInf, bInf, cInf, anyNan;
  logic pSign, cSign, prodZero, prodInf, invalidOp;
  logic [7:0] ma, mb, mc;
  logic [15:0] pm;
  logic signed [10:0] sP, sC, refExp, erPre, er;
  logic [10:0] shamt;
  logic [FRAME_W-1:0] frameP, frameC, alP, alC, mag, norm;
  logic signed [21:0] vP, vC, total;
  logic [21:0] magW;
  logic resNeg, guardBit, stickyBit, roundUp;
  logic [4:0] lz;
  logic [8:0] m9;
  logic [FRAC_W-1:0] fracOut;
  logic [LANE_W-1:0] general;
  logic [1:0] unusedMagHi;
  logic unusedM9;

  always_comb begin
    aExp = opA[14:7];
    bExp = opB[14:7];
    cExp = opC[14:7];
    aZero = (aExp == '0);
    bZero = (bExp == '0);
    cZero = (cExp == '0);
    aInf = (aExp == '1) && (opA[6:0] == '0);
    bInf = (bExp == '1) && (opB[6:0] == '0);
    cInf = (cExp == '1) && (opC[6:0] == '0);
    anyNan = ((aExp == '1) && (opA[6:0] != '0)) ||
             ((bExp == '1) && (opB[6:0] != '0)) ||
             ((cExp == '1) && (opC[6:0] != '0));
    pSign = ~opA[15] ^ opB[15];
    cSign = opC[15];
    prodZero = aZero || bZero;
    prodInf = aInf || bInf;
    invalidOp = (aInf && bZero) || (aZero && bInf) ||
                (prodInf && cInf && (pSign != cSign));

    ma = {1'b1, opA[6:0]};
    mb = {1'b1, opB[6:0]};
    mc = {1'b1, opC[6:0]};
    pm = 16'(ma) * 16'(mb);
    sP = $signed({3'b000, aExp}) + $signed({3'b000, bExp}) - 11'sd127;
    sC = cZero ? sP : $signed({3'b000, cExp});
    frameP = {1'b0, pm, 3'b000};
    frameC = cZero ? '0 : {2'b00, mc, 10'd0};

    if (sP >= sC) begin
      refExp = sP;
      shamt = 11'(sP - sC);
      alP = frameP;
      alC = shiftSticky(frameC, shamt);
    end else begin
      refExp = sC;
      shamt = 11'(sC - sP);
      alP = shiftSticky(frameP, shamt);
      alC = frameC;
    end

    vP = pSign ? -$signed({2'b00, alP}) : $signed({2'b00, alP});
    vC = cSign ? -$signed({2'b00, alC}) : $signed({2'b00, alC});
    total = vP + vC;
    resNeg = total[21];
    magW = resNeg ? 22'(-total) : 22'(total);
    mag = magW[FRAME_W-1:0];
    unusedMagHi = magW[21:20];

    lz = 5'd0;
    for (int i = 0; i < FRAME_W; i++) begin
      if (mag[i]) lz = 5'(FRAME_W - 1 - i);
    end
    norm = mag << lz;
    erPre = refExp + 11'sd2 - $signed({6'd0, lz});
    guardBit = norm[11];
    stickyBit = |norm[10:0];
    roundUp = guardBit && (stickyBit || norm[12]);
    m9 = {1'b0, norm[19:12]} + {8'd0, roundUp};
    unusedM9 = m9[7];
    if (m9[8]) begin
      er = erPre + 11'sd1;
      fracOut = '0;
    end else begin
      er = erPre;
      fracOut = m9[6:0];
    end

    if (mag == '0)              general = 16'h0000;
    else if (er >= 11'sd255)    general = {resNeg, 8'hFF, 7'd0};
    else if (er <= 11'sd0)      general = {resNeg, 15'd0};
    else                        general = {resNeg, er[7:0], fracOut};

    if (anyNan || invalidOp)    laneOut = QNAN_DEFAULT;
    else if (prodInf)           laneOut = {pSign, 8'hFF, 7'd0};
    else if (cInf)              laneOut = opC;
    else if (prodZero) begin
      if (!cZero)               laneOut = opC;
      else if (pSign == cSign)  laneOut = {cSign, 15'd0};
      else                      laneOut = 16'h0000;
    end else                    laneOut = general;
  end
endmodule

// File: rtl/bfms_ctrl.sv
module bfms_ctrl
  import bfms_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic               inValid,
  input  logic [2*LANES-1:0] predMask,
  output logic [LANES-1:0]   laneEn,
  output ctlStrobe_t         ctl
);
  logic [LANES-1:0] unusedOddBits;

  for (genvar g = 0; g < LANES; g++) begin : gSel
    assign laneEn[g] = predMask[2*g];
    assign unusedOddBits[g] = predMask[2*g+1];
  end

  always_comb begin
    ctl.capture = inValid;
    ctl.zeroSrc = ~|laneEn;
  end
endmodule

// File: rtl/bfms_datapath.sv
module bfms_datapath
  import bfms_pkg::*;
#(
  parameter int LANES   = 4,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctlStrobe_t              ctl,
  input  logic [LANES-1:0]        laneEn,
  input  logic [LANES*LANE_W-1:0] srcA,
  input  logic [LANES*LANE_W-1:0] srcB,
  input  logic [LANES*LANE_W-1:0] srcAcc,
  output logic                    outValid,
  output logic [LANES*LANE_W-1:0] result
);
  localparam int VW = LANES * LANE_W;
  logic [VW-1:0] opA, opB, laneRes, selRes;

  assign opA = ctl.zeroSrc ? '0 : srcA;
  assign opB = ctl.zeroSrc ? '0 : srcB;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    bfms_lane u_lane (
      .opA    (opA[g*LANE_W +: LANE_W]),
      .opB    (opB[g*LANE_W +: LANE_W]),
      .opC    (srcAcc[g*LANE_W +: LANE_W]),
      .laneOut(laneRes[g*LANE_W +: LANE_W])
    );
    assign selRes[g*LANE_W +: LANE_W] = laneEn[g] ? laneRes[g*LANE_W +: LANE_W]
                                                  : srcAcc[g*LANE_W +: LANE_W];
  end

  if (OUT_REG) begin : gReg
    logic [VW-1:0] resQ;
    logic validQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        resQ <= '0;
        validQ <= 1'b0;
      end else begin
        validQ <= ctl.capture;
        if (ctl.capture) resQ <= selRes;
      end
    end
    assign result = resQ;
    assign outValid = validQ;
  end else begin : gComb
    assign result = selRes;
    assign outValid = ctl.capture;
  end
endmodule

// File: rtl/bfms_top.sv
module bfms_top
  import bfms_pkg::*;
#(
  parameter int LANES   = 4,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [LANES*16-1:0]     srcA,
  input  logic [LANES*16-1:0]     srcB,
  input  logic [LANES*16-1:0]     srcAcc,
  input  logic [LANES*2-1:0]      predMask,
  output logic                    outValid,
  output logic [LANES*16-1:0]     result
);
  ctlStrobe_t ctl;
  logic [LANES-1:0] laneEn;

  bfms_ctrl #(.LANES(LANES)) u_ctrl (
    .inValid (inValid),
    .predMask(predMask),
    .laneEn  (laneEn),
    .ctl     (ctl)
  );

  bfms_datapath #(.LANES(LANES), .OUT_REG(OUT_REG)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .laneEn  (laneEn),
    .srcA    (srcA),
    .srcB    (srcB),
    .srcAcc  (srcAcc),
    .outValid(outValid),
    .result  (result)
  );
endmodule

// File: rtl/bfms_chk.sv
module bfms_chk #(
  parameter int LANES   = 4,
  parameter bit OUT_REG = 1'b1
) (
  input logic                clk,
  input logic                rstN,
  input logic                inValid,
  input logic [LANES*16-1:0] srcAcc,
  input logic [LANES*2-1:0]  predMask,
  input logic                outValid,
  input logic [LANES*16-1:0] result
);
  if (OUT_REG) begin : gRegChecks
    a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
      inValid |=> outValid);
    a_r11_idle_no_valid: assert property (@(posedge clk) disable iff (!rstN)
      !inValid |=> !outValid);
    a_r11_hold_result: assert property (@(posedge clk) disable iff (!rstN)
      !inValid |=> $stable(result));

    for (genvar g = 0; g < LANES; g++) begin : gLaneChk
      a_r3_inactive_pass: assert property (@(posedge clk) disable iff (!rstN)
        (inValid && !predMask[2*g]) |=> (result[g*16 +: 16] == $past(srcAcc[g*16 +: 16])));
      a_r7_nan_addend: assert property (@(posedge clk) disable iff (!rstN)
        (inValid && predMask[2*g] && (srcAcc[g*16+7 +: 8] == 8'hFF) &&
         (srcAcc[g*16 +: 7] != 7'd0)) |=> (result[g*16 +: 16] == 16'h7FC0));
    end
  end
endmodule

bind bfms_top bfms_chk #(.LANES(LANES), .OUT_REG(OUT_REG)) u_bfms_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .srcAcc  (srcAcc),
  .predMask(predMask),
  .outValid(outValid),
  .result  (result)
);

// File: tb/bfms_top_bench.sv
module bfms_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [LANES*16-1:0] srcA = '0, srcB = '0, srcAcc = '0;
  logic [LANES*2-1:0] predMask = '0;
  logic outValid;
  logic [LANES*16-1:0] result;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bfms_top #(.LANES(LANES), .OUT_REG(1'b1)) u_bfms_top (
    .clk(clk), .rstN(rstN), .inValid(inValid), .srcA(srcA), .srcB(srcB),
    .srcAcc(srcAcc), .predMask(predMask), .outValid(outValid), .result(result)
  );

  task automatic checkLane(input int lane, input logic [15:0] expv, input string req);
    logic [15:0] got;
    got = result[lane*16 +: 16];
    total++;
    if (got !== expv) begin
      bad++;
      $display("FAIL %s lane%0d got=%h exp=%h", req, lane, got, expv);
    end
  endtask

  task automatic checkBit(input logic got, input logic expv, input string req);
    total++;
    if (got !== expv) begin
      bad++;
      $display("FAIL %s got=%b exp=%b", req, got, expv);
    end
  endtask

  task automatic applyVec(input logic [63:0] a, input logic [63:0] b,
                          input logic [63:0] c, input logic [7:0] p);
    @(negedge clk);
    srcA = a; srcB = b; srcAcc = c; predMask = p; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic testReset;
    checkBit(outValid, 1'b0, "R11 reset valid");
    total++;
    if (result !== '0) begin
      bad++;
      $display("FAIL R11 reset result got=%h exp=0", result);
    end
  endtask

  task automatic testBasic;
    applyVec({16'h3F81, 16'h4000, 16'hC000, 16'h4000},
             {16'h3F81, 16'h4000, 16'h4040, 16'h4040},
             {16'h3F82, 16'h3F80, 16'h3F80, 16'h40E0}, 8'h55);
    checkBit(outValid, 1'b1, "R11 valid after capture");
    checkLane(0, 16'h3F80, "R2 7-2*3");
    checkLane(1, 16'h40E0, "R2 1+2*3");
    checkLane(2, 16'hC040, "R2 1-2*2");
    checkLane(3, 16'hB880, "R2 fused single rounding");
  endtask

  task automatic testRound;
    applyVec({16'hBF80, 16'hBF80, 16'hBF80, 16'hBF80},
             {16'h3B40, 16'h3BC0, 16'h3B80, 16'h3B80},
             {16'h3F80, 16'h3F80, 16'h3F81, 16'h3F80}, 8'h55);
    checkLane(0, 16'h3F80, "R5 tie to even down");
    checkLane(1, 16'h3F82, "R5 tie to even up");
    checkLane(2, 16'h3F81, "R5 above tie");
    checkLane(3, 16'h3F80, "R5 below tie");
  endtask

  task automatic testOverflow;
    applyVec({16'h3F80, 16'hBF80, 16'h4000, 16'hC000},
             {16'h3F80, 16'h7F7F, 16'h7F7F, 16'h7F7F},
             {16'h3F80, 16'h7F7F, 16'h0000, 16'h0000}, 8'h55);
    checkLane(0, 16'h7F80, "R6 positive overflow");
    checkLane(1, 16'hFF80, "R6 negative overflow");
    checkLane(2, 16'h7F80, "R6 sum overflow");
    checkLane(3, 16'h0000, "R10 exact cancel");
  endtask

  task automatic testSpecial;
    applyVec({16'h7F80, 16'h7F80, 16'h7F80, 16'h7FC1},
             {16'h3F80, 16'h3F80, 16'h0000, 16'h3F80},
             {16'h3F80, 16'h7F80, 16'h3F80, 16'h3F80}, 8'h55);
    checkLane(0, 16'h7FC0, "R7 NaN operand");
    checkLane(1, 16'h7FC0, "R7 inf times zero");
    checkLane(2, 16'h7FC0, "R7 inf minus inf");
    checkLane(3, 16'hFF80, "R8 inf product");
    applyVec({16'h4000, 16'hFF80, 16'h3F80, 16'h3F80},
             {16'h3F80, 16'h3F80, 16'h3F80, 16'h3F80},
             {16'hFF80, 16'h7F80, 16'h7FC1, 16'hFF80}, 8'h55);
    checkLane(0, 16'hFF80, "R8 inf addend");
    checkLane(1, 16'h7FC0, "R7 NaN addend");
    checkLane(2, 16'h7F80, "R8 same-sign infinities");
    checkLane(3, 16'hFF80, "R8 inf addend finite product");
  endtask

  task automatic testFlush;
    applyVec({16'h0080, 16'h0000, 16'h0080, 16'h0040},
             {16'h3F00, 16'h0000, 16'h3F00, 16'h3F80},
             {16'h0005, 16'h0001, 16'h0000, 16'h3F80}, 8'h55);
    checkLane(0, 16'h3F80, "R9 subnormal input");
    checkLane(1, 16'h8000, "R9 tiny result flushed");
    checkLane(2, 16'h0000, "R9 subnormal addend as zero");
    checkLane(3, 16'h8000, "R9 tiny result with flushed addend");
  endtask

  task automatic testZeros;
    applyVec({16'h0000, 16'h4040, 16'h0000, 16'h8000},
             {16'h3F80, 16'h4000, 16'h3F80, 16'h3F80},
             {16'h0000, 16'h40C0, 16'h8000, 16'h8000}, 8'h55);
    checkLane(0, 16'h0000, "R10 opposite zeros");
    checkLane(1, 16'h8000, "R10 negative zeros");
    checkLane(2, 16'h0000, "R10 cancel 6-6");
    checkLane(3, 16'h0000, "R10 mixed zeros");
  endtask

  task automatic testPredicate;
    applyVec({4{16'h4000}}, {4{16'h4040}},
             {16'h40E0, 16'h40E0, 16'h40E0, 16'h7F81}, 8'b0000_0100);
    checkLane(0, 16'h7F81, "R3 inactive NaN addend");
    checkLane(1, 16'h3F80, "R1 bit2 enables lane1");
    checkLane(2, 16'h40E0, "R3 inactive lane2");
    checkLane(3, 16'h40E0, "R3 inactive lane3");
    applyVec({4{16'h4000}}, {4{16'h4040}}, {4{16'h40E0}}, 8'b0100_0001);
    checkLane(0, 16'h3F80, "R1 lane0 active");
    checkLane(1, 16'h40E0, "R1 lane1 inactive");
    checkLane(2, 16'h40E0, "R1 lane2 inactive");
    checkLane(3, 16'h3F80, "R1 lane3 active");
  endtask

  task automatic testNoActive;
    applyVec({4{16'h4000}}, {4{16'h4040}},
             {16'h8000, 16'hFF80, 16'h7F81, 16'h1234}, 8'hAA);
    checkLane(0, 16'h1234, "R4 odd bits only");
    checkLane(1, 16'h7F81, "R4 NaN addend kept");
    checkLane(2, 16'hFF80, "R4 inf addend kept");
    checkLane(3, 16'h8000, "R4 negative zero kept");
  endtask

  task automatic testHold;
    @(negedge clk);
    srcA = {4{16'h3F80}}; srcB = {4{16'h3F80}}; srcAcc = {4{16'h4000}}; predMask = 8'hFF;
    @(negedge clk);
    @(negedge clk);
    checkBit(outValid, 1'b0, "R11 no valid when idle");
    checkLane(0, 16'h1234, "R11 hold lane0");
    checkLane(3, 16'h8000, "R11 hold lane3");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3 + 1);
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    testBasic();
    testRound();
    testOverflow();
    testSpecial();
    testFlush();
    testZeros();
    testPredicate();
    testNoActive();
    testHold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule